// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs the state change a processor core makes when it takes an exception or an interrupt. On the clock edge where the trap strobe is high, it picks the handling level (machine or supervisor) from the delegation masks. It saves the interrupted pc, the cause and the trap value into that level's registers, and it pushes the interrupt-enable and privilege stack of that level. It also computes the handler address from that level's trap-vector register. The new pc and the new privilege are presented one cycle later as a registered redirect.

The block owns the status stacking fields and the two banks of saved-pc, cause and trap-value registers, and it exposes them as outputs. Software writes reach them through a simple select-and-data port, and a trap in the same cycle takes priority over such a write. The delegation masks and the vector bases come in as inputs from the rest of the register file. Privilege encoding is user = 0, supervisor = 1, machine = 3.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every status field, every saved-pc, cause and trap-value register, and the redirect-valid output read zero.
- R2: The delegation mask is `int_deleg` for asynchronous traps and `exc_deleg` for synchronous traps.
- R3: A trap is handled at supervisor level only when the current privilege is not machine, the effective cause is below XLEN, and the mask bit indexed by that cause is 1; otherwise it is handled at machine level.
- R4: The handling level's trap-value register receives `trap_addr` only for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15; all other traps, interrupts included, write zero there.
- R5: A synchronous trap whose cause is 8, 9 or 11 is an environment call and is recorded as 8 plus the current privilege (11 from machine, 9 from supervisor, 8 from user); delegation uses the recorded cause.
- R6: On supervisor entry: SPIE (status bit 5) takes the old SIE (bit 1), SPP (bit 8) takes bit 0 of the current privilege, and SIE is cleared; the machine fields keep their values.
- R7: On machine entry: MPIE (bit 7) takes the old MIE (bit 3), MPP (bits 12:11) takes the current privilege, and MIE is cleared; the supervisor fields and the supervisor saved-pc, cause and trap-value registers keep their values.
- R8: The handling level's cause register receives the effective cause zero-extended, with bit XLEN-1 set for interrupts, and its saved-pc register receives `cur_pc`.
- R9: The redirect pc is the handling level's vector register with bits 1:0 cleared, plus 4 times the cause only when the trap is asynchronous and the vector's bits 1:0 equal 1.
- R10: One cycle after each trap strobe, `redir_valid` is high for exactly one cycle, and `redir_priv` is 1 or 3 to match the handling level.
- R11: A trap in the same cycle as a software write wins over that write; in a cycle without a trap, a software write stores its data (select 0 status, 1 machine saved-pc, 2 machine cause, 3 machine trap value, 4 supervisor saved-pc, 5 supervisor cause, 6 supervisor trap value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Take a trap on this edge |
| trap_async | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | pc of the interrupted instruction |
| cur_priv | input | 2 | Current privilege (0, 1 or 3) |
| exc_deleg | input | XLEN | Exception delegation mask |
| int_deleg | input | XLEN | Interrupt delegation mask |
| m_vec | input | XLEN | Machine trap-vector register |
| s_vec | input | XLEN | Supervisor trap-vector register |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 3 | Software write target select |
| sw_wdata | input | XLEN | Software write data |
| status_o | output | XLEN | Status word with stacking fields |
| m_epc_o | output | XLEN | Machine saved pc |
| m_cause_o | output | XLEN | Machine cause |
| m_tval_o | output | XLEN | Machine trap value |
| s_epc_o | output | XLEN | Supervisor saved pc |
| s_cause_o | output | XLEN | Supervisor cause |
| s_tval_o | output | XLEN | Supervisor trap value |
| redir_valid | output | 1 | Redirect pulse |
| redir_pc | output | XLEN | Handler address |
| redir_priv | output | 2 | Privilege after entry |

## Verification
A trap strobe and a software register write can fall in the same cycle. The bench provokes this by driving a machine-level trap together with a write to the machine saved-pc register on the same edge. It judges the result by reading back that register, which must hold the trapping pc and not the written data. A write on its own in a later cycle is read back to show that the port still works when no trap competes with it.

// File: rtl/trap_entry_pkg.sv
// Shared constants and types for the trap entry controller.
// Assumes privilege codes U=0, S=1, M=3; code 2 is never presented.
package trap_entry_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // Bit positions of the stacking fields inside the status word
    localparam int BIT_SIE    = 1;
    localparam int BIT_MIE    = 3;
    localparam int BIT_SPIE   = 5;
    localparam int BIT_MPIE   = 7;
    localparam int BIT_SPP    = 8;
    localparam int BIT_MPP_LO = 11;

    // Exception causes that carry a faulting address
    localparam logic [15:0] ADDR_CAUSES = 16'b1011_0000_1111_0011;

    // Software write targets
    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_MEPC   = 3'd1;
    localparam logic [2:0] SEL_MCAUSE = 3'd2;
    localparam logic [2:0] SEL_MTVAL  = 3'd3;
    localparam logic [2:0] SEL_SEPC   = 3'd4;
    localparam logic [2:0] SEL_SCAUSE = 3'd5;
    localparam logic [2:0] SEL_STVAL  = 3'd6;

    typedef struct packed {
        logic       sie;
        logic       spie;
        logic       spp;
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
    } stack_t;

endpackage

// File: rtl/trap_route.sv
// Decides the handling level, the recorded cause and the trap value.
// Purely combinational. Assumes CAUSE_W >= clog2(XLEN) and CAUSE_W >= 4.
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 7
) (
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [1:0]         priv_i,
    input  logic [XLEN-1:0]    addr_i,
    input  logic [XLEN-1:0]    exc_deleg_i,
    input  logic [XLEN-1:0]    int_deleg_i,
    output logic [CAUSE_W-1:0] eff_cause_o,
    output logic               to_s_o,
    output logic [XLEN-1:0]    tval_o
);
    localparam int IDXW = $clog2(XLEN);

    logic            is_ecall;
    logic [XLEN-1:0] mask;
    logic            in_range;
    logic            addr_kind;

    // Remap environment calls to the caller's privilege
    always_comb begin
        is_ecall = !async_i && (cause_i == CAUSE_W'(8) || cause_i == CAUSE_W'(9)
                                || cause_i == CAUSE_W'(11));
        eff_cause_o = is_ecall ? CAUSE_W'(8 + int'(priv_i)) : cause_i;
    end

    // Pick the delegation mask and decide the handling level
    always_comb begin
        mask     = async_i ? int_deleg_i : exc_deleg_i;
        in_range = int'(eff_cause_o) < XLEN;
        to_s_o   = (priv_i != PRIV_M) && in_range && mask[eff_cause_o[IDXW-1:0]];
    end

    // Trap value is the address only for address-bearing exceptions
    always_comb begin
        addr_kind = !async_i && (int'(eff_cause_o) < 16) && ADDR_CAUSES[eff_cause_o[3:0]];
        tval_o    = addr_kind ? addr_i : '0;
    end
endmodule

// File: rtl/trap_vector.sv
// Computes the handler address from a trap-vector register.
// Mode value 1 in bits 1:0 vectors interrupts; other modes go to the base.
module trap_vector #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 7
) (
    input  logic [XLEN-1:0]    vec_i,
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    target_o
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Aligned base plus optional per-cause offset
    always_comb begin
        base     = {vec_i[XLEN-1:2], 2'b00};
        offset   = (async_i && vec_i[1:0] == 2'b01) ? (XLEN'(cause_i) << 2) : '0;
        target_o = base + offset;
    end
endmodule

// File: rtl/trap_csr_bank.sv
// Holds the stacking fields and both banks of saved-pc, cause and
// trap-value registers. A trap commits on the strobe edge and overrides
// any software write presented in the same cycle.
module trap_csr_bank
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic               to_s,
    input  logic [CAUSE_W-1:0] eff_cause,
    input  logic [XLEN-1:0]    tval,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic               sw_we,
    input  logic [2:0]         sw_sel,
    input  logic [XLEN-1:0]    sw_wdata,
    output stack_t             stack_q,
    output logic [XLEN-1:0]    m_epc_q,
    output logic [XLEN-1:0]    m_cause_q,
    output logic [XLEN-1:0]    m_tval_q,
    output logic [XLEN-1:0]    s_epc_q,
    output logic [XLEN-1:0]    s_cause_q,
    output logic [XLEN-1:0]    s_tval_q
);
    logic [XLEN-1:0] cause_word;

    // Cause word: interrupt flag at the top, code at the bottom
    always_comb begin
        cause_word         = XLEN'(eff_cause);
        cause_word[XLEN-1] = trap_async;
    end

    // Register update: trap first, otherwise software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stack_q   <= '0;
            m_epc_q   <= '0;
            m_cause_q <= '0;
            m_tval_q  <= '0;
            s_epc_q   <= '0;
            s_cause_q <= '0;
            s_tval_q  <= '0;
        end else if (trap_valid) begin
            if (to_s) begin
                stack_q.spie <= stack_q.sie;
                stack_q.spp  <= cur_priv[0];
                stack_q.sie  <= 1'b0;
                s_epc_q      <= cur_pc;
                s_cause_q    <= cause_word;
                s_tval_q     <= tval;
            end else begin
                stack_q.mpie <= stack_q.mie;
                stack_q.mpp  <= cur_priv;
                stack_q.mie  <= 1'b0;
                m_epc_q      <= cur_pc;
                m_cause_q    <= cause_word;
                m_tval_q     <= tval;
            end
        end else if (sw_we) begin
            case (sw_sel)
                SEL_STATUS: begin
                    stack_q.sie  <= sw_wdata[BIT_SIE];
                    stack_q.mie  <= sw_wdata[BIT_MIE];
                    stack_q.spie <= sw_wdata[BIT_SPIE];
                    stack_q.mpie <= sw_wdata[BIT_MPIE];
                    stack_q.spp  <= sw_wdata[BIT_SPP];
                    stack_q.mpp  <= sw_wdata[BIT_MPP_LO+1:BIT_MPP_LO];
                end
                SEL_MEPC:   m_epc_q   <= sw_wdata;
                SEL_MCAUSE: m_cause_q <= sw_wdata;
                SEL_MTVAL:  m_tval_q  <= sw_wdata;
                SEL_SEPC:   s_epc_q   <= sw_wdata;
                SEL_SCAUSE: s_cause_q <= sw_wdata;
                SEL_STVAL:  s_tval_q  <= sw_wdata;
                default: ;
            endcase
        end
    end

    AST_S_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && to_s) |=> (!stack_q.sie && stack_q.spie == $past(stack_q.sie)
                                  && stack_q.mie == $past(stack_q.mie))); // R6
    AST_M_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !to_s) |=> (!stack_q.mie && stack_q.mpie == $past(stack_q.mie)
                                   && stack_q.mpp == $past(cur_priv))); // R7
    AST_M_KEEPS_S: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !to_s) |=> $stable(s_epc_q)); // R7
    AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !to_s) |=> (m_cause_q[XLEN-1] == $past(trap_async))); // R8
    AST_INT_NO_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !to_s && trap_async) |=> (m_tval_q == '0)); // R4
    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !to_s && sw_we && sw_sel == SEL_MEPC) |=> (m_epc_q == $past(cur_pc))); // R11
endmodule

// File: rtl/trap_entry_ctrl.sv
// Top of the trap entry controller: routes the trap, updates the
// privileged registers on the strobe edge and registers the redirect
// (new pc and privilege) for one cycle. Status word carries only the
// stacking fields; all other bits read zero.
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_async,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    int_deleg,
    input  logic [XLEN-1:0]    m_vec,
    input  logic [XLEN-1:0]    s_vec,
    input  logic               sw_we,
    input  logic [2:0]         sw_sel,
    input  logic [XLEN-1:0]    sw_wdata,
    output logic [XLEN-1:0]    status_o,
    output logic [XLEN-1:0]    m_epc_o,
    output logic [XLEN-1:0]    m_cause_o,
    output logic [XLEN-1:0]    m_tval_o,
    output logic [XLEN-1:0]    s_epc_o,
    output logic [XLEN-1:0]    s_cause_o,
    output logic [XLEN-1:0]    s_tval_o,
    output logic               redir_valid,
    output logic [XLEN-1:0]    redir_pc,
    output logic [1:0]         redir_priv
);
    logic [CAUSE_W-1:0] eff_cause;
    logic               to_s;
    logic [XLEN-1:0]    tval;
    logic [XLEN-1:0]    target;
    stack_t             stack_q;

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
        .async_i     (trap_async),
        .cause_i     (trap_cause),
        .priv_i      (cur_priv),
        .addr_i      (trap_addr),
        .exc_deleg_i (exc_deleg),
        .int_deleg_i (int_deleg),
        .eff_cause_o (eff_cause),
        .to_s_o      (to_s),
        .tval_o      (tval)
    );

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vector (
        .vec_i    (to_s ? s_vec : m_vec),
        .async_i  (trap_async),
        .cause_i  (eff_cause),
        .target_o (target)
    );

    trap_csr_bank #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_valid (trap_valid),
        .trap_async (trap_async),
        .to_s       (to_s),
        .eff_cause  (eff_cause),
        .tval       (tval),
        .cur_pc     (cur_pc),
        .cur_priv   (cur_priv),
        .sw_we      (sw_we),
        .sw_sel     (sw_sel),
        .sw_wdata   (sw_wdata),
        .stack_q    (stack_q),
        .m_epc_q    (m_epc_o),
        .m_cause_q  (m_cause_o),
        .m_tval_q   (m_tval_o),
        .s_epc_q    (s_epc_o),
        .s_cause_q  (s_cause_o),
        .s_tval_q   (s_tval_o)
    );

    // Assemble the status word from the stacking fields
    always_comb begin
        status_o                              = '0;
        status_o[BIT_SIE]                     = stack_q.sie;
        status_o[BIT_MIE]                     = stack_q.mie;
        status_o[BIT_SPIE]                    = stack_q.spie;
        status_o[BIT_MPIE]                    = stack_q.mpie;
        status_o[BIT_SPP]                     = stack_q.spp;
        status_o[BIT_MPP_LO+1:BIT_MPP_LO]     = stack_q.mpp;
    end

    // Register the redirect for one cycle after the trap edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            redir_priv  <= PRIV_M;
        end else begin
            redir_valid <= trap_valid;
            if (trap_valid) begin
                redir_pc   <= target;
                redir_priv <= to_s ? PRIV_S : PRIV_M;
            end
        end
    end

    AST_REDIR_ON: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redir_valid); // R10
    AST_REDIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !redir_valid); // R10
    AST_REDIR_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_priv == PRIV_S || redir_priv == PRIV_M)); // R10
    AST_M_STAYS_M: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && cur_priv == PRIV_M) |=> (redir_priv == PRIV_M)); // R3
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_pc[1:0] == 2'b00)); // R9
endmodule

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;
    localparam int XLEN = 32;
    localparam int CW   = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n, trap_valid, trap_async, sw_we;
    logic [CW-1:0]   trap_cause;
    logic [XLEN-1:0] trap_addr, cur_pc, exc_deleg, int_deleg, m_vec, s_vec, sw_wdata;
    logic [1:0]      cur_priv;
    logic [2:0]      sw_sel;
    logic [XLEN-1:0] status_o, m_epc_o, m_cause_o, m_tval_o, s_epc_o, s_cause_o, s_tval_o, redir_pc;
    logic            redir_valid;
    logic [1:0]      redir_priv;

    trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) u_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
        .trap_cause(trap_cause), .trap_addr(trap_addr), .cur_pc(cur_pc), .cur_priv(cur_priv),
        .exc_deleg(exc_deleg), .int_deleg(int_deleg), .m_vec(m_vec), .s_vec(s_vec),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .status_o(status_o),
        .m_epc_o(m_epc_o), .m_cause_o(m_cause_o), .m_tval_o(m_tval_o), .s_epc_o(s_epc_o),
        .s_cause_o(s_cause_o), .s_tval_o(s_tval_o), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .redir_priv(redir_priv)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    logic            e_sie, e_spie, e_spp, e_mie, e_mpie;
    logic [1:0]      e_mpp;
    logic [XLEN-1:0] e_mepc, e_mcause, e_mtval, e_sepc, e_scause, e_stval;

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] stat_word();
        logic [XLEN-1:0] w = '0;
        w[1] = e_sie; w[3] = e_mie; w[5] = e_spie; w[7] = e_mpie; w[8] = e_spp;
        w[12:11] = e_mpp;
        return w;
    endfunction

    task automatic sw_write(logic [2:0] sel, logic [XLEN-1:0] data);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = data;
        @(negedge clk);
        sw_we = 1'b0;
        if (sel == 3'd0) begin
            e_sie = data[1]; e_mie = data[3]; e_spie = data[5]; e_mpie = data[7];
            e_spp = data[8]; e_mpp = data[12:11];
        end
    endtask

    // Drive one trap, update the model and check every output
    task automatic do_trap(logic [1:0] p, logic a, int c, logic [XLEN-1:0] addr,
                           logic [XLEN-1:0] pc, logic with_sw);
        int eff;
        logic to_s;
        logic [XLEN-1:0] mask, tv, vec, tgt, cw;
        eff  = (!a && (c == 8 || c == 9 || c == 11)) ? 8 + int'(p) : c;
        mask = a ? int_deleg : exc_deleg;
        to_s = (p != 2'd3) && (eff < XLEN) && mask[eff % XLEN];
        tv   = (!a && (eff inside {0, 1, 4, 5, 6, 7, 12, 13, 15})) ? addr : '0;
        vec  = to_s ? s_vec : m_vec;
        tgt  = {vec[XLEN-1:2], 2'b00} + ((a && vec[1:0] == 2'b01) ? XLEN'(eff * 4) : '0);
        cw   = XLEN'(eff);
        cw[XLEN-1] = a;
        @(negedge clk);
        trap_valid = 1'b1; trap_async = a; trap_cause = CW'(c); trap_addr = addr;
        cur_pc = pc; cur_priv = p;
        sw_we = with_sw; sw_sel = 3'd1; sw_wdata = 32'h5555_AAAA;
        @(negedge clk);
        trap_valid = 1'b0; sw_we = 1'b0;
        if (to_s) begin
            e_spie = e_sie; e_spp = p[0]; e_sie = 1'b0;
            e_sepc = pc; e_scause = cw; e_stval = tv;
        end else begin
            e_mpie = e_mie; e_mpp = p; e_mie = 1'b0;
            e_mepc = pc; e_mcause = cw; e_mtval = tv;
        end
        chk("R10", "redir_valid", 64'(redir_valid), 64'd1);
        chk("R3 R2", "redir_priv", 64'(redir_priv), to_s ? 64'd1 : 64'd3);
        chk("R9", "redir_pc", 64'(redir_pc), 64'(tgt));
        chk("R6 R7", "status", 64'(status_o), 64'(stat_word()));
        chk("R5 R8", "m_cause", 64'(m_cause_o), 64'(e_mcause));
        chk("R5 R8", "s_cause", 64'(s_cause_o), 64'(e_scause));
        chk(with_sw ? "R11" : "R8", "m_epc", 64'(m_epc_o), 64'(e_mepc));
        chk("R7", "s_epc", 64'(s_epc_o), 64'(e_sepc));
        chk("R4", "m_tval", 64'(m_tval_o), 64'(e_mtval));
        chk("R4", "s_tval", 64'(s_tval_o), 64'(e_stval));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] privs [3];
        int n;
        privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
        rst_n = 1'b0; trap_valid = 1'b0; trap_async = 1'b0; trap_cause = '0;
        trap_addr = '0; cur_pc = '0; cur_priv = 2'd3; sw_we = 1'b0; sw_sel = '0;
        sw_wdata = '0; exc_deleg = 32'h0000_A36B; int_deleg = 32'h0000_5C94;
        m_vec = 32'h0000_1000; s_vec = 32'h0000_2000;
        e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0; e_mpie = 0; e_mpp = 0;
        e_mepc = 0; e_mcause = 0; e_mtval = 0; e_sepc = 0; e_scause = 0; e_stval = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "status", 64'(status_o), 64'd0);
        chk("R1", "m_epc", 64'(m_epc_o), 64'd0);
        chk("R1", "s_cause", 64'(s_cause_o), 64'd0);
        chk("R1", "redir_valid", 64'(redir_valid), 64'd0);

        // Sweep privilege, trap kind and cause with varying vector modes
        n = 0;
        for (int pi = 0; pi < 3; pi++) begin
            for (int a = 0; a < 2; a++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [XLEN-1:0] sv;
                    sv = '0;
                    sv[1] = n[0]; sv[3] = n[1]; sv[5] = n[2]; sv[7] = n[3];
                    sv[8] = n[4]; sv[12:11] = n[6:5];
                    sw_write(3'd0, sv);
                    m_vec = 32'h0000_1000 | XLEN'(c % 4);
                    s_vec = 32'h0000_2000 | XLEN'((c / 2) % 4);
                    do_trap(privs[pi], a[0], c, 32'hDEAD_0000 + XLEN'(c),
                            32'h0000_4000 + XLEN'(n * 4), 1'b0);
                    n++;
                end
            end
        end

        // R2: same cause, mask differs between the two kinds
        exc_deleg = 32'h0000_0020; int_deleg = 32'h0000_0000;
        m_vec = 32'h0000_1001; s_vec = 32'h0000_2001;
        do_trap(2'd1, 1'b0, 5, 32'h0000_0777, 32'h0000_8000, 1'b0);
        do_trap(2'd1, 1'b1, 5, 32'h0000_0777, 32'h0000_8004, 1'b0);

        // R3: cause at or above XLEN never delegates
        exc_deleg = 32'hFFFF_FFFF; int_deleg = 32'hFFFF_FFFF;
        do_trap(2'd0, 1'b0, 40, 32'h0000_0999, 32'h0000_8008, 1'b0);
        do_trap(2'd0, 1'b1, 70, 32'h0000_0999, 32'h0000_800C, 1'b0);
        // R10: redirect lasts one cycle
        @(negedge clk);
        chk("R10", "redir_valid drop", 64'(redir_valid), 64'd0);

        // R11: trap beats a same-cycle software write to machine saved pc
        do_trap(2'd3, 1'b0, 2, 32'h0000_0111, 32'h0000_9000, 1'b1);
        // R11: software write alone lands
        sw_write(3'd3, 32'h1234_5678);
        chk("R11", "m_tval write", 64'(m_tval_o), 64'h1234_5678);
        sw_write(3'd4, 32'h0000_ABC0);
        chk("R11", "s_epc write", 64'(s_epc_o), 64'h0000_ABC0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule